// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block checks every instruction fetch and data access against a per-region access mode. The 32-bit address space is split into eight equal regions, each one eighth of the space. The top address bits select the region. Fetches and data accesses use two separate mode tables, so one region can be, for example, fetchable but not writable. For each request the unit returns, one cycle later, either an exception with its cause or the cache handling the access should receive: allocate, no-allocate, bypass, write-through, write-back or isolate.

The unit only classifies accesses and performs none of them. A single configuration write port loads any entry of either table. Two elaboration parameters describe the surrounding core:
- `HAS_CACHE` says whether caches exist. When they do not, every access that does not raise an exception is reported as bypass.
- `WB_OPTION` says whether the write-back store policy is available.

Top module: `region_prot_unit`

## Requirements
- R1: The region of an address is its bits [31:29]. Addresses 0x1FFFFFFF and 0x20000000 fall in regions 0 and 1.
- R2: Each of the two tables has 8 entries of 4 bits. A write with `cfg_table`=0 changes only the fetch table, and a write with `cfg_table`=1 changes only the data table, at entry `cfg_region`.
- R3: After reset, every entry of both tables holds mode 0010, so every fetch, load and store reports bypass.
- R4: A response is registered. `*_rsp_valid` is high exactly one cycle after a valid request. When no request was made, the cause and attribute outputs read 0 in the following cycle.
- R5: Mode 0000 gives fetch→exception, load→no-allocate and store→write-through. Mode 0001 gives fetch→allocate, load→allocate and store→write-through. Mode 0010 gives bypass for all three.
- R6: Mode 0011, modes 0101 through 1101, and mode 1111 raise an exception for fetch, load and store alike. The fetch case of 0011 is defined as an exception.
- R7: Mode 0100 gives allocate for fetch and load. For a store it gives write-back when `WB_OPTION`=1 and write-through when `WB_OPTION`=0.
- R8: Mode 1110 raises an exception for a fetch and reports isolate for loads and stores.
- R9: With `HAS_CACHE`=0, every access that does not raise an exception reports bypass. The exceptions are the same as with caches.
- R10: Cause codes are 0 none, 1 fetch, 2 load and 3 store. Attribute codes are 0 none, 1 allocate, 2 no-allocate, 3 bypass, 4 write-through, 5 write-back and 6 isolate. When an exception is raised, the attribute is 0.
- R11: A table write to the region being looked up in the same cycle does not affect that lookup. It takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifetch_valid | input | 1 | Fetch request present |
| ifetch_addr | input | 32 | Fetch address |
| dreq_valid | input | 1 | Data request present |
| dreq_addr | input | 32 | Data address |
| dreq_is_store | input | 1 | 1 = store, 0 = load |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_table | input | 1 | 0 = fetch table, 1 = data table |
| cfg_region | input | 3 | Entry index |
| cfg_mode | input | 4 | New access mode |
| ifetch_rsp_valid | output | 1 | Fetch verdict valid |
| ifetch_exc_cause | output | 2 | Fetch exception cause (R10 code) |
| ifetch_attr | output | 3 | Fetch cache attribute (R10 code) |
| dreq_rsp_valid | output | 1 | Data verdict valid |
| dreq_exc_cause | output | 2 | Data exception cause (R10 code) |
| dreq_attr | output | 3 | Data cache attribute (R10 code) |

## Verification
The hardest case to reach is a configuration write that collides with a lookup of the same region in the same cycle. The old mode must still govern that lookup. The bench drives the write and a fetch to that region on one edge, checks for the old outcome, and then repeats the fetch alone to see the new outcome. Parameter-dependent store policy and the cacheless bypass rule are covered by three instances with different parameters, all fed the same stimulus while the bench sweeps all sixteen modes through every kind of access.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

    localparam int MODE_W = 4;
    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_NOALLOC = 4'b0000;
    localparam mode_t MODE_WTHRU   = 4'b0001;
    localparam mode_t MODE_BYPASS  = 4'b0010;
    localparam mode_t MODE_NOSUPP  = 4'b0011;
    localparam mode_t MODE_WBACK   = 4'b0100;
    localparam mode_t MODE_ISOLATE = 4'b1110;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_FETCH = 2'd1,
        CAUSE_LOAD  = 2'd2,
        CAUSE_STORE = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ATTR_NONE    = 3'd0,
        ATTR_ALLOC   = 3'd1,
        ATTR_NOALLOC = 3'd2,
        ATTR_BYPASS  = 3'd3,
        ATTR_WTHRU   = 3'd4,
        ATTR_WBACK   = 3'd5,
        ATTR_ISOLATE = 3'd6
    } attr_e;

    typedef struct packed {
        cause_e cause;
        attr_e  attr;
    } verdict_t;

    function automatic cause_e cause_of(kind_e k);
        case (k)
            KIND_FETCH: return CAUSE_FETCH;
            KIND_LOAD:  return CAUSE_LOAD;
            default:    return CAUSE_STORE;
        endcase
    endfunction

    // Raw policy for one access; ATTR_NONE means the access faults.
    function automatic attr_e raw_attr(mode_t m, kind_e k, bit wb_opt);
        attr_e a;
        a = ATTR_NONE;
        case (m)
            MODE_NOALLOC: a = (k == KIND_FETCH) ? ATTR_NONE :
                              (k == KIND_LOAD)  ? ATTR_NOALLOC : ATTR_WTHRU;
            MODE_WTHRU:   a = (k == KIND_STORE) ? ATTR_WTHRU : ATTR_ALLOC;
            MODE_BYPASS:  a = ATTR_BYPASS;
            MODE_WBACK:   a = (k != KIND_STORE) ? ATTR_ALLOC :
                              (wb_opt ? ATTR_WBACK : ATTR_WTHRU);
            MODE_ISOLATE: a = (k == KIND_FETCH) ? ATTR_NONE : ATTR_ISOLATE;
            default:      a = ATTR_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/rpu_mode_table.sv
module rpu_mode_table
    import rpu_pkg::*;
#(
    parameter int    ENTRIES    = 8,
    parameter mode_t RESET_MODE = MODE_BYPASS,
    localparam int   IDX_W      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  mode_t            wr_mode,
    input  logic [IDX_W-1:0] rd_idx,
    output mode_t            rd_mode
);

    mode_t entry_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= RESET_MODE;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry_q[g] <= wr_mode;
            end
        end
    end

    // Read returns the stored value; a write in this cycle is seen next cycle.
    assign rd_mode = entry_q[rd_idx];

endmodule

// File: rtl/rpu_classify.sv
module rpu_classify
    import rpu_pkg::*;
#(
    parameter bit HAS_CACHE = 1'b1,
    parameter bit WB_OPTION = 1'b1
) (
    input  mode_t    mode,
    input  kind_e    kind,
    output verdict_t verdict
);

    attr_e policy;

    always_comb begin
        policy = raw_attr(mode, kind, WB_OPTION);
        if (policy == ATTR_NONE) begin
            verdict.cause = cause_of(kind);
            verdict.attr  = ATTR_NONE;
        end else begin
            verdict.cause = CAUSE_NONE;
            verdict.attr  = HAS_CACHE ? policy : ATTR_BYPASS;
        end
    end

endmodule

// File: rtl/region_prot_unit.sv
module region_prot_unit
    import rpu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int REGIONS   = 8,
    parameter bit HAS_CACHE = 1'b1,
    parameter bit WB_OPTION = 1'b1,
    localparam int RIDX_W   = $clog2(REGIONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ifetch_valid,
    input  logic [ADDR_W-1:0] ifetch_addr,
    input  logic              dreq_valid,
    input  logic [ADDR_W-1:0] dreq_addr,
    input  logic              dreq_is_store,
    input  logic              cfg_we,
    input  logic              cfg_table,
    input  logic [RIDX_W-1:0] cfg_region,
    input  logic [3:0]        cfg_mode,
    output logic              ifetch_rsp_valid,
    output logic [1:0]        ifetch_exc_cause,
    output logic [2:0]        ifetch_attr,
    output logic              dreq_rsp_valid,
    output logic [1:0]        dreq_exc_cause,
    output logic [2:0]        dreq_attr
);

    localparam verdict_t IDLE_VERDICT = '{cause: CAUSE_NONE, attr: ATTR_NONE};

    logic [RIDX_W-1:0] f_region, d_region;
    mode_t             f_mode, d_mode;
    kind_e             d_kind;
    verdict_t          f_verdict, d_verdict;
    verdict_t          f_q, d_q;
    logic              f_vld_q, d_vld_q;

    assign f_region = ifetch_addr[ADDR_W-1 -: RIDX_W];
    assign d_region = dreq_addr[ADDR_W-1 -: RIDX_W];
    assign d_kind   = dreq_is_store ? KIND_STORE : KIND_LOAD;

    rpu_mode_table #(.ENTRIES(REGIONS), .RESET_MODE(MODE_BYPASS)) fetch_tbl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we && !cfg_table),
        .wr_idx  (cfg_region),
        .wr_mode (cfg_mode),
        .rd_idx  (f_region),
        .rd_mode (f_mode)
    );

    rpu_mode_table #(.ENTRIES(REGIONS), .RESET_MODE(MODE_BYPASS)) data_tbl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we && cfg_table),
        .wr_idx  (cfg_region),
        .wr_mode (cfg_mode),
        .rd_idx  (d_region),
        .rd_mode (d_mode)
    );

    rpu_classify #(.HAS_CACHE(HAS_CACHE), .WB_OPTION(WB_OPTION)) fetch_cls_i (
        .mode    (f_mode),
        .kind    (KIND_FETCH),
        .verdict (f_verdict)
    );

    rpu_classify #(.HAS_CACHE(HAS_CACHE), .WB_OPTION(WB_OPTION)) data_cls_i (
        .mode    (d_mode),
        .kind    (d_kind),
        .verdict (d_verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            f_vld_q <= 1'b0;
            d_vld_q <= 1'b0;
            f_q     <= IDLE_VERDICT;
            d_q     <= IDLE_VERDICT;
        end else begin
            f_vld_q <= ifetch_valid;
            d_vld_q <= dreq_valid;
            f_q     <= ifetch_valid ? f_verdict : IDLE_VERDICT;
            d_q     <= dreq_valid   ? d_verdict : IDLE_VERDICT;
        end
    end

    assign ifetch_rsp_valid = f_vld_q;
    assign ifetch_exc_cause = f_q.cause;
    assign ifetch_attr      = f_q.attr;
    assign dreq_rsp_valid   = d_vld_q;
    assign dreq_exc_cause   = d_q.cause;
    assign dreq_attr        = d_q.attr;

endmodule

// File: rtl/rpu_checker.sv
module rpu_checker #(
    parameter bit HAS_CACHE = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       ifetch_valid,
    input logic       dreq_valid,
    input logic       dreq_is_store,
    input logic       ifetch_rsp_valid,
    input logic [1:0] ifetch_exc_cause,
    input logic [2:0] ifetch_attr,
    input logic       dreq_rsp_valid,
    input logic [1:0] dreq_exc_cause,
    input logic [2:0] dreq_attr
);

    // R4
    fetch_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ifetch_valid |=> ifetch_rsp_valid);

    // R4
    data_latency_chk: assert property (@(posedge clk) disable iff (rst)
        dreq_valid |=> dreq_rsp_valid);

    // R4
    fetch_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ifetch_valid |=> (!ifetch_rsp_valid && ifetch_exc_cause == 2'd0 && ifetch_attr == 3'd0));

    // R4
    data_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dreq_valid |=> (!dreq_rsp_valid && dreq_exc_cause == 2'd0 && dreq_attr == 3'd0));

    // R10
    fetch_cause_kind_chk: assert property (@(posedge clk) disable iff (rst)
        ifetch_rsp_valid |-> (ifetch_exc_cause == 2'd0 || ifetch_exc_cause == 2'd1));

    // R10
    store_cause_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (dreq_valid && dreq_is_store) |=> (dreq_exc_cause == 2'd0 || dreq_exc_cause == 2'd3));

    // R10
    load_cause_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (dreq_valid && !dreq_is_store) |=> (dreq_exc_cause == 2'd0 || dreq_exc_cause == 2'd2));

    // R10
    fetch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ifetch_rsp_valid |-> ((ifetch_exc_cause != 2'd0) == (ifetch_attr == 3'd0)));

    // R10
    data_excl_chk: assert property (@(posedge clk) disable iff (rst)
        dreq_rsp_valid |-> ((dreq_exc_cause != 2'd0) == (dreq_attr == 3'd0)));

    // R9
    nocache_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (!HAS_CACHE && dreq_rsp_valid && dreq_exc_cause == 2'd0) |-> dreq_attr == 3'd3);

endmodule

bind region_prot_unit rpu_checker #(.HAS_CACHE(HAS_CACHE)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .ifetch_valid     (ifetch_valid),
    .dreq_valid       (dreq_valid),
    .dreq_is_store    (dreq_is_store),
    .ifetch_rsp_valid (ifetch_rsp_valid),
    .ifetch_exc_cause (ifetch_exc_cause),
    .ifetch_attr      (ifetch_attr),
    .dreq_rsp_valid   (dreq_rsp_valid),
    .dreq_exc_cause   (dreq_exc_cause),
    .dreq_attr        (dreq_attr)
);

// File: tb/region_prot_unit_tb.sv
module region_prot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ifetch_valid = 1'b0;
    logic [31:0] ifetch_addr = '0;
    logic        dreq_valid = 1'b0;
    logic [31:0] dreq_addr = '0;
    logic        dreq_is_store = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_table = 1'b0;
    logic [2:0]  cfg_region = '0;
    logic [3:0]  cfg_mode = '0;

    logic       f_v [3];
    logic [1:0] f_c [3];
    logic [2:0] f_a [3];
    logic       d_v [3];
    logic [1:0] d_c [3];
    logic [2:0] d_a [3];

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // 0: caches + write-back, 1: caches without write-back, 2: no caches
    region_prot_unit #(.HAS_CACHE(1'b1), .WB_OPTION(1'b1)) dut_i (
        .clk(clk), .rst(rst), .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
        .dreq_valid(dreq_valid), .dreq_addr(dreq_addr), .dreq_is_store(dreq_is_store),
        .cfg_we(cfg_we), .cfg_table(cfg_table), .cfg_region(cfg_region), .cfg_mode(cfg_mode),
        .ifetch_rsp_valid(f_v[0]), .ifetch_exc_cause(f_c[0]), .ifetch_attr(f_a[0]),
        .dreq_rsp_valid(d_v[0]), .dreq_exc_cause(d_c[0]), .dreq_attr(d_a[0]));

    region_prot_unit #(.HAS_CACHE(1'b1), .WB_OPTION(1'b0)) wt_i (
        .clk(clk), .rst(rst), .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
        .dreq_valid(dreq_valid), .dreq_addr(dreq_addr), .dreq_is_store(dreq_is_store),
        .cfg_we(cfg_we), .cfg_table(cfg_table), .cfg_region(cfg_region), .cfg_mode(cfg_mode),
        .ifetch_rsp_valid(f_v[1]), .ifetch_exc_cause(f_c[1]), .ifetch_attr(f_a[1]),
        .dreq_rsp_valid(d_v[1]), .dreq_exc_cause(d_c[1]), .dreq_attr(d_a[1]));

    region_prot_unit #(.HAS_CACHE(1'b0), .WB_OPTION(1'b1)) nc_i (
        .clk(clk), .rst(rst), .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
        .dreq_valid(dreq_valid), .dreq_addr(dreq_addr), .dreq_is_store(dreq_is_store),
        .cfg_we(cfg_we), .cfg_table(cfg_table), .cfg_region(cfg_region), .cfg_mode(cfg_mode),
        .ifetch_rsp_valid(f_v[2]), .ifetch_exc_cause(f_c[2]), .ifetch_attr(f_a[2]),
        .dreq_rsp_valid(d_v[2]), .dreq_exc_cause(d_c[2]), .dreq_attr(d_a[2]));

    // Reference: kind 0 fetch, 1 load, 2 store; returns {cause, attr}
    function automatic logic [4:0] expect_of(int mode, int kind, bit hc, bit wb);
        int a;
        a = 0;
        if (kind == 0) begin
            if (mode == 1 || mode == 4) a = 1;
            else if (mode == 2) a = 3;
        end else if (kind == 1) begin
            if (mode == 0) a = 2;
            else if (mode == 1 || mode == 4) a = 1;
            else if (mode == 2) a = 3;
            else if (mode == 14) a = 6;
        end else begin
            if (mode == 0 || mode == 1) a = 4;
            else if (mode == 2) a = 3;
            else if (mode == 4) a = wb ? 5 : 4;
            else if (mode == 14) a = 6;
        end
        if (a == 0) return {2'(kind + 1), 3'd0};
        if (!hc) a = 3;
        return {2'd0, 3'(a)};
    endfunction

    function automatic string tag_of(int mode, int inst);
        if (inst == 2) return "R9";
        if (mode <= 2) return "R5";
        if (mode == 4) return "R7";
        if (mode == 14) return "R8";
        return "R6";
    endfunction

    task automatic check(string req, string what, int got, int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic cfg_write(bit tbl, int region, int mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_table = tbl; cfg_region = 3'(region); cfg_mode = 4'(mode);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one request cycle; return after the registering edge.
    task automatic access(bit fv, logic [31:0] fa, bit dv, logic [31:0] da, bit st);
        @(negedge clk);
        ifetch_valid = fv; ifetch_addr = fa;
        dreq_valid = dv; dreq_addr = da; dreq_is_store = st;
        @(posedge clk);
        #1;
        ifetch_valid = 1'b0; dreq_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // R3 R1: every region of both tables starts as bypass
    task automatic t_reset_state();
        check("R4", "idle rsp_valid after reset", int'(f_v[0]), 0);
        for (int r = 0; r < 8; r++) begin
            access(1'b1, {3'(r), 29'h40}, 1'b1, {3'(r), 29'h80}, 1'b0);
            check("R3", "fetch attr reset", int'(f_a[0]), 3);
            check("R3", "load attr reset", int'(d_a[0]), 3);
            access(1'b0, '0, 1'b1, {3'(r), 29'h4}, 1'b1);
            check("R3", "store attr reset", int'(d_a[0]), 3);
        end
    endtask

    // R1: region boundary between 0 and 1
    task automatic t_boundary();
        cfg_write(1'b1, 0, 15);
        access(1'b0, '0, 1'b1, 32'h1FFF_FFFF, 1'b0);
        check("R1", "0x1FFFFFFF load cause", int'(d_c[0]), 2);
        access(1'b0, '0, 1'b1, 32'h2000_0000, 1'b0);
        check("R1", "0x20000000 load attr", int'(d_a[0]), 3);
        access(1'b0, '0, 1'b1, 32'hE000_0000, 1'b1);
        check("R1", "region 7 store attr", int'(d_a[0]), 3);
    endtask

    // R2: tables are separate
    task automatic t_independence();
        cfg_write(1'b0, 3, 15);
        access(1'b1, 32'h6000_0010, 1'b1, 32'h6000_0020, 1'b0);
        check("R2", "fetch table write faults fetch", int'(f_c[0]), 1);
        check("R2", "fetch table write leaves data", int'(d_a[0]), 3);
        cfg_write(1'b1, 4, 15);
        access(1'b1, 32'h8000_0000, 1'b1, 32'h8000_0000, 1'b1);
        check("R2", "data table write leaves fetch", int'(f_a[0]), 3);
        check("R2", "data table write faults store", int'(d_c[0]), 3);
    endtask

    // R11: colliding write and lookup
    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_table = 1'b0; cfg_region = 3'd5; cfg_mode = 4'd15;
        ifetch_valid = 1'b1; ifetch_addr = 32'hA000_0100;
        @(posedge clk);
        #1;
        cfg_we = 1'b0; ifetch_valid = 1'b0;
        check("R11", "colliding fetch uses old mode", int'(f_a[0]), 3);
        check("R11", "colliding fetch no cause", int'(f_c[0]), 0);
        access(1'b1, 32'hA000_0100, 1'b0, '0, 1'b0);
        check("R11", "next fetch uses new mode", int'(f_c[0]), 1);
    endtask

    // R5..R10: all modes on all instances
    task automatic t_mode_sweep();
        for (int m = 0; m < 16; m++) begin
            int r;
            logic [4:0] e;
            r = m % 8;
            cfg_write(1'b0, r, m);
            cfg_write(1'b1, r, m);
            access(1'b1, {3'(r), 29'h1230}, 1'b1, {3'(r), 29'h4560}, 1'b0);
            for (int i = 0; i < 3; i++) begin
                e = expect_of(m, 0, i != 2, i != 1);
                check(tag_of(m, i), $sformatf("mode %0d inst %0d fetch cause", m, i), int'(f_c[i]), int'(e[4:3]));
                check(tag_of(m, i), $sformatf("mode %0d inst %0d fetch attr", m, i), int'(f_a[i]), int'(e[2:0]));
                e = expect_of(m, 1, i != 2, i != 1);
                check("R10", $sformatf("mode %0d inst %0d load cause", m, i), int'(d_c[i]), int'(e[4:3]));
                check(tag_of(m, i), $sformatf("mode %0d inst %0d load attr", m, i), int'(d_a[i]), int'(e[2:0]));
            end
            access(1'b0, '0, 1'b1, {3'(r), 29'h789}, 1'b1);
            for (int i = 0; i < 3; i++) begin
                e = expect_of(m, 2, i != 2, i != 1);
                check("R10", $sformatf("mode %0d inst %0d store cause", m, i), int'(d_c[i]), int'(e[4:3]));
                check(tag_of(m, i), $sformatf("mode %0d inst %0d store attr", m, i), int'(d_a[i]), int'(e[2:0]));
            end
        end
    endtask

    // R4: one-cycle response, idle clears
    task automatic t_idle();
        access(1'b1, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0);
        check("R4", "fetch rsp_valid after request", int'(f_v[0]), 1);
        check("R4", "data rsp_valid after request", int'(d_v[0]), 1);
        access(1'b0, '0, 1'b0, '0, 1'b0);
        check("R4", "fetch rsp_valid idle", int'(f_v[0]), 0);
        check("R4", "fetch attr idle", int'(f_a[0]), 0);
        check("R4", "data cause idle", int'(d_c[0]), 0);
        check("R4", "data attr idle", int'(d_a[0]), 0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_boundary();
        t_independence();
        t_same_cycle();
        do_reset();
        t_mode_sweep();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule